// File: doc/BRIEF.md
# Serial-to-Parallel Memory Bus Bridge

This block lets a small controller with only a few general-purpose pins drive a parallel memory bus. The controller bit-bangs bytes into the bridge one bit at a time. It then strobes each finished byte into a three-place staging chain. The chain's three places drive an 8-bit data bus and a 16-bit address bus, split into a high and a low byte. For a read, the controller strobes a second pin low. The bridge then captures the 8-bit parallel data input and returns it on a serial output, one bit per serial clock.

The serial clock, the two byte strobes and the serial data pin are all asynchronous to the system clock. Each one passes through a two-flop synchroniser, and its edges are detected in the system clock domain. Each bus has an active-low output-enable input. The bridge turns it into a registered, active-high enable that travels beside the bus value; the bridge contains no tri-state drivers. A RAM write is three committed bytes: the data byte first, then the address low byte, then the address high byte.

Top module: `serbus_bridge`

## Requirements
- R1: A synchronous active-high reset clears the data, address-high and address-low outputs to 0, drives the serial output to 0, and deasserts both bus enables.
- R2: Serial input bits are taken most significant bit first. Each bit is sampled on a rising edge of the serial clock and must be stable before that edge.
- R3: A rising edge on the write strobe commits the byte being assembled, provided at least 8 bits have arrived since the last strobe. The commit shifts the chain one place: address-low moves to data, address-high moves to address-low, and the new byte enters address-high.
- R4: After three committed bytes in the order data, address low, address high, the data output, address-low output and address-high output hold those three values, in that order.
- R5: A write strobe that follows fewer than 8 serial bits since the last strobe leaves every bus output unchanged. Every strobe, of either kind, restarts the bit count, so the next full byte is still taken correctly.
- R6: When more than 8 bits arrive before a write strobe, the committed byte is the last 8 bits received.
- R7: A falling edge on the active-low read strobe loads the parallel data input into the output shift register. From that point the serial output shows bit 7 of the loaded byte, before any serial clock edge.
- R8: Each later rising edge of the serial clock moves the serial output to the next lower bit. After all 8 bits have been shifted out, the serial output reads 0.
- R9: Each bus enable output is the registered inverse of its own active-low output-enable input, one system clock later. The address enable and the data enable are independent.
- R10: A transition on the serial clock or on either strobe takes effect at the outputs on the third rising system clock edge after the transition: two edges for the synchroniser and one for the action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial write data, MSB first |
| ser_clk | input | 1 | Serial bit clock, shared by both directions |
| wr_stb | input | 1 | Commit strobe, active on its rising edge |
| rd_stb_n | input | 1 | Active-low read strobe, loads data_in |
| addr_oe_n | input | 1 | Active-low address output enable |
| data_oe_n | input | 1 | Active-low data output enable |
| data_in | input | 8 | Parallel read data from the bus |
| ser_out | output | 1 | Serial read data, MSB first |
| addr_hi | output | 8 | Address high byte |
| addr_lo | output | 8 | Address low byte |
| addr_en | output | 1 | Address bus drive enable |
| data_out | output | 8 | Data bus value |
| data_en | output | 1 | Data bus drive enable |

## Verification
The hardest cases to reach from the ports are misaligned bytes. One is a strobe after only part of a byte, which must be ignored. The other is a byte with extra leading bits, which must keep only its last eight. The stimulus builds both on purpose: it sends a short run of bits and strobes, and it sends nine bits before a strobe. It then pushes a full byte and checks that the chain picked up the right value. The exact three-edge latency after a read strobe is checked by sampling the serial output after the second and after the third system clock edge.

// File: rtl/serbus_bridge.sv
module serbus_bridge #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ser_in,
  input  logic          ser_clk,
  input  logic          wr_stb,
  input  logic          rd_stb_n,
  input  logic          addr_oe_n,
  input  logic          data_oe_n,
  input  logic [DW-1:0] data_in,
  output logic          ser_out,
  output logic [DW-1:0] addr_hi,
  output logic [DW-1:0] addr_lo,
  output logic          addr_en,
  output logic [DW-1:0] data_out,
  output logic          data_en
);
  localparam int CW = $clog2(DW + 1);

  logic [2:0]    clk_s, wr_s, rd_s;
  logic [1:0]    din_s;
  logic [DW-1:0] shin, shout;
  logic [CW-1:0] cnt;
  logic          bit_rise, wr_rise, rd_fall, full;

  assign bit_rise = clk_s[1] & ~clk_s[2];
  assign wr_rise  = wr_s[1]  & ~wr_s[2];
  assign rd_fall  = ~rd_s[1] & rd_s[2];
  assign full     = (cnt == CW'(DW));
  assign ser_out  = shout[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_s <= '0;
      wr_s  <= '0;
      rd_s  <= '1;
      din_s <= '0;
    end else begin
      clk_s <= {clk_s[1:0], ser_clk};
      wr_s  <= {wr_s[1:0], wr_stb};
      rd_s  <= {rd_s[1:0], rd_stb_n};
      din_s <= {din_s[0], ser_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shin <= '0;
      cnt  <= '0;
    end else begin
      if (bit_rise) shin <= {shin[DW-2:0], din_s[1]};
      if (wr_rise || rd_fall) cnt <= '0;
      else if (bit_rise && !full) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      addr_lo  <= '0;
      addr_hi  <= '0;
    end else if (wr_rise && full) begin
      data_out <= addr_lo;
      addr_lo  <= addr_hi;
      addr_hi  <= shin;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) shout <= '0;
    else if (rd_fall) shout <= data_in;
    else if (bit_rise) shout <= {shout[DW-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_en <= 1'b0;
      data_en <= 1'b0;
    end else begin
      addr_en <= ~addr_oe_n;
      data_en <= ~data_oe_n;
    end
  end
endmodule

// File: rtl/serbus_bridge_chk.sv
module serbus_bridge_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ser_clk,
  input logic          wr_stb,
  input logic          rd_stb_n,
  input logic          addr_oe_n,
  input logic          data_oe_n,
  input logic          ser_out,
  input logic [DW-1:0] addr_hi,
  input logic [DW-1:0] addr_lo,
  input logic          addr_en,
  input logic [DW-1:0] data_out,
  input logic          data_en
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=>
    (data_out == '0 && addr_lo == '0 && addr_hi == '0 && !ser_out && !addr_en && !data_en));

  // R9
  addr_en_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> addr_en == !$past(addr_oe_n));

  // R9
  data_en_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> data_en == !$past(data_oe_n));

  // R3
  chain_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && data_out != $past(data_out)) |-> data_out == $past(addr_lo));

  // R3
  chain_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && addr_lo != $past(addr_lo)) |-> addr_lo == $past(addr_hi));

  // R10
  push_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && addr_hi != $past(addr_hi)) |-> ($past(wr_stb, 3) && !$past(wr_stb, 4)));

  // R10
  ser_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ser_out != $past(ser_out)) |->
      ($past(ser_clk, 3) != $past(ser_clk, 4) || $past(rd_stb_n, 3) != $past(rd_stb_n, 4)));
endmodule

bind serbus_bridge serbus_bridge_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .ser_clk(ser_clk), .wr_stb(wr_stb), .rd_stb_n(rd_stb_n),
  .addr_oe_n(addr_oe_n), .data_oe_n(data_oe_n), .ser_out(ser_out),
  .addr_hi(addr_hi), .addr_lo(addr_lo), .addr_en(addr_en),
  .data_out(data_out), .data_en(data_en)
);

// File: tb/serbus_bridge_test.sv
module serbus_bridge_test;
  logic clk = 0, rst = 1;
  logic ser_in = 0, ser_clk = 0, wr_stb = 0, rd_stb_n = 1;
  logic addr_oe_n = 1, data_oe_n = 1;
  logic [7:0] data_in = 0;
  logic ser_out, addr_en, data_en;
  logic [7:0] addr_hi, addr_lo, data_out;
  int vectors = 0, errors = 0;
  logic [7:0] e_d = 0, e_lo = 0, e_hi = 0;

  always #2 clk = ~clk;

  serbus_bridge uut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .ser_clk(ser_clk), .wr_stb(wr_stb),
    .rd_stb_n(rd_stb_n), .addr_oe_n(addr_oe_n), .data_oe_n(data_oe_n),
    .data_in(data_in), .ser_out(ser_out), .addr_hi(addr_hi), .addr_lo(addr_lo),
    .addr_en(addr_en), .data_out(data_out), .data_en(data_en)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    ser_in = b;  wait_cyc(4);
    ser_clk = 1; wait_cyc(4);
    ser_clk = 0; wait_cyc(4);
  endtask

  task automatic send_bits(logic [7:0] v, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic commit();
    wr_stb = 1; wait_cyc(4);
    wr_stb = 0; wait_cyc(4);
  endtask

  function automatic void push(logic [7:0] b);
    e_d = e_lo; e_lo = e_hi; e_hi = b;
  endfunction

  task automatic check_bus(string req);
    check(req, {8'h0, e_hi, e_lo, e_d}, {8'h0, addr_hi, addr_lo, data_out});
  endtask

  task automatic write_ram(logic [7:0] d, logic [15:0] a);
    send_bits(d, 8);        commit(); push(d);
    send_bits(a[7:0], 8);   commit(); push(a[7:0]);
    send_bits(a[15:8], 8);  commit(); push(a[15:8]);
  endtask

  task automatic read_byte(logic [7:0] v, output logic [7:0] got);
    data_in = v;
    rd_stb_n = 0; wait_cyc(4);
    rd_stb_n = 1; wait_cyc(4);
    for (int i = 7; i >= 0; i--) begin
      got[i] = ser_out;
      ser_clk = 1; wait_cyc(4);
      ser_clk = 0; wait_cyc(4);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [7:0] got;
    process::self().srandom(32'h5eed);
    wait_cyc(4);
    // R1 reset state
    check("R1", {addr_hi, addr_lo, data_out, 5'b0, ser_out, addr_en, data_en}, 32'h0);
    rst = 0; wait_cyc(2);

    // R9 enables
    addr_oe_n = 0; wait_cyc(2);
    check("R9", {addr_en, data_en}, 2'b10);
    data_oe_n = 0; addr_oe_n = 1; wait_cyc(2);
    check("R9", {addr_en, data_en}, 2'b01);
    addr_oe_n = 0; wait_cyc(2);
    check("R9", {addr_en, data_en}, 2'b11);

    // R4 directed example, R2 MSB first
    write_ram(8'hA5, 16'h0001);
    check("R4", {8'h0, addr_hi, addr_lo, data_out}, 32'h0001A5);
    check_bus("R2");

    // R7 R8 read back
    read_byte(8'h5A, got);
    check("R7", got, 8'h5A);
    check("R8", ser_out, 1'b0);

    // R10 latency and R7 MSB before clock
    data_in = 8'h80;
    rd_stb_n = 0;
    @(posedge clk); @(posedge clk); #1;
    check("R10", ser_out, 1'b0);
    @(posedge clk); #1;
    check("R7", ser_out, 1'b1);
    wait_cyc(4); rd_stb_n = 1; wait_cyc(4);

    // R5 partial byte ignored, then realigned
    send_bits(8'h1F, 5); commit();
    check_bus("R5");
    send_bits(8'h3C, 8); commit(); push(8'h3C);
    check_bus("R5");

    // R6 nine bits keep last eight
    send_bit(1'b1); send_bits(8'h42, 8); commit(); push(8'h42);
    check_bus("R6");

    // R3 single push shifts the chain
    send_bits(8'hE7, 8); commit(); push(8'hE7);
    check_bus("R3");

    // random mix
    for (int k = 0; k < 20; k++) begin
      logic [7:0] d, v;
      logic [15:0] a;
      d = 8'($urandom); a = 16'($urandom); v = 8'($urandom);
      addr_oe_n = 1'($urandom); data_oe_n = 1'($urandom);
      write_ram(d, a);
      check("R4", {8'h0, addr_hi, addr_lo, data_out}, {8'h0, a, d});
      check("R9", {addr_en, data_en}, {~addr_oe_n, ~data_oe_n});
      read_byte(v, got);
      check("R8", got, v);
    end

    // R1 reset again
    rst = 1; wait_cyc(2);
    check("R1", {addr_hi, addr_lo, data_out, 5'b0, ser_out, addr_en, data_en}, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule